// File: doc/BRIEF.md
# Paired Stride Address Sequencer

This block walks a nest of up to six counted loops and, at each step, issues one packet command for a tensor copy. Every command carries a source address, a destination address and a byte length. Both addresses come from the same loop indices. Each side has its own base and its own stride per loop level, so the copy can reorder dimensions (for example, transpose a layout) while it moves the data. The block only generates addresses. A downstream mover reads the packet at the source address and writes it at the destination address.

A client presents a descriptor on the configuration inputs and pulses `start` while the block is idle. The descriptor holds a limit and two strides for each loop level, two base addresses and a packet length. Level 0 is the outermost loop and level `NUM_DIMS-1` is the innermost, fastest-changing loop. A descriptor that needs fewer levels sets the spare levels to limit 1. Commands leave on a valid/ready handshake. After the last command is accepted, `done` pulses once and the block returns to idle.

The controller has three states:
- `ST_IDLE`: waiting for a start request.
- `ST_EMIT`: presenting commands.
- `ST_DONE`: the one-cycle completion pulse.

Its transitions are:
- IDLE→EMIT on `start`.
- EMIT→EMIT on a handshake that is not the final one, or on a stall.
- EMIT→DONE on the handshake of the final packet.
- DONE→IDLE unconditionally.

Top module: `pair_stride_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `busy`, `cmd_valid` and `done` are all low.
- R2: A `start` pulse seen while idle latches the descriptor. In the next cycle `cmd_valid` is high, with `cmd_src_addr` equal to the source base and `cmd_dst_addr` equal to the destination base.
- R3: For loop indices i0..i5, the source address is the source base plus the sum of ik × source stride k, and the destination address is the destination base plus the sum of ik × destination stride k. Both sums wrap modulo 2^ADDR_W. Limit and strides of level k sit at bits [k*W +: W] of their flattened inputs.
- R4: Level NUM_DIMS-1 advances on every accepted command. A level wraps to 0 and carries into the next lower-numbered level when its index reaches its limit minus one.
- R5: The number of commands per descriptor equals the product of all level limits. A level with limit 1 adds no steps. `done` stays low until the final command is accepted.
- R6: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, both addresses and `cmd_len` hold their values, and no loop index advances.
- R7: In the cycle after the final handshake, `done` is high for exactly one cycle with `cmd_valid` low. The cycle after that, `busy` is low and a new `start` is accepted.
- R8: A `start` pulse while busy is ignored. The running walk keeps the descriptor latched at its own start.
- R9: `cmd_len` equals the latched packet length, 1 to 4096 bytes, for every command of the descriptor.
- R10: For limits 8, 8 and 1, source strides 2048/256, destination strides 256/2048, destination base 16384 and 256-byte packets, the second command (a=0, b=1) carries source address 256 and destination address 18432.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch request, honoured only while idle |
| cfg_limit | input | NUM_DIMS*LIMIT_W | Iteration count per level, level k at [k*LIMIT_W +: LIMIT_W] |
| cfg_src_stride | input | NUM_DIMS*ADDR_W | Source stride per level |
| cfg_dst_stride | input | NUM_DIMS*ADDR_W | Destination stride per level |
| cfg_src_base | input | ADDR_W | Source base address |
| cfg_dst_base | input | ADDR_W | Destination base address |
| cfg_pkt_len | input | LEN_W | Packet length in bytes, 1..MAX_PKT |
| busy | output | 1 | A descriptor is being walked or completing |
| cmd_valid | output | 1 | A packet command is presented |
| cmd_ready | input | 1 | Consumer accepts the presented command |
| cmd_src_addr | output | ADDR_W | Source byte address of the packet |
| cmd_dst_addr | output | ADDR_W | Destination byte address of the packet |
| cmd_len | output | LEN_W | Packet length in bytes |
| done | output | 1 | One-cycle completion pulse |

## Verification
The properties assume a legal descriptor: every level limit is at least 1, and the packet length lies between 1 and 4096. They also assume the consumer may hold `cmd_ready` low for any time, but only the configuration inputs change between a stall and its release. The stimulus keeps within this. Random limits are drawn from 1 to 3, so products stay small, and random lengths from 1 to 4096. Directed cases use all-ones limits and the two length extremes. Ready is either held high or drawn at random, so that stalls of several cycles occur. One run pulses `start` with a changed base in the middle of a walk.

// File: rtl/pair_stride_seq_pkg.sv
package pair_stride_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EMIT = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/pss_loop_level.sv
module pss_loop_level #(
    parameter int LIMIT_W = 16,
    parameter int ADDR_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [LIMIT_W-1:0] lim_in,
    input  logic [ADDR_W-1:0]  src_stride_in,
    input  logic [ADDR_W-1:0]  dst_stride_in,
    output logic               at_last,
    output logic               carry,
    output logic [ADDR_W-1:0]  src_off,
    output logic [ADDR_W-1:0]  dst_off
);

    logic [LIMIT_W-1:0] lim_q;
    logic [LIMIT_W-1:0] idx_q;
    logic [ADDR_W-1:0]  sstr_q;
    logic [ADDR_W-1:0]  dstr_q;
    logic [LIMIT_W:0]   idx_next;

    assign idx_next = {1'b0, idx_q} + {{LIMIT_W{1'b0}}, 1'b1};
    assign at_last  = idx_next >= {1'b0, lim_q};
    assign carry    = step && at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q   <= '0;
            idx_q   <= '0;
            sstr_q  <= '0;
            dstr_q  <= '0;
            src_off <= '0;
            dst_off <= '0;
        end else if (load) begin
            lim_q   <= lim_in;
            sstr_q  <= src_stride_in;
            dstr_q  <= dst_stride_in;
            idx_q   <= '0;
            src_off <= '0;
            dst_off <= '0;
        end else if (step) begin
            if (at_last) begin
                idx_q   <= '0;
                src_off <= '0;
                dst_off <= '0;
            end else begin
                idx_q   <= idx_next[LIMIT_W-1:0];
                src_off <= src_off + sstr_q;
                dst_off <= dst_off + dstr_q;
            end
        end
    end

endmodule

// File: rtl/pss_offset_sum.sv
module pss_offset_sum #(
    parameter int NUM_DIMS = 6,
    parameter int ADDR_W   = 32
) (
    input  logic [ADDR_W-1:0]          base,
    input  logic [NUM_DIMS*ADDR_W-1:0] offs,
    output logic [ADDR_W-1:0]          addr
);

    always_comb begin
        addr = base;
        for (int k = 0; k < NUM_DIMS; k++) begin
            addr = addr + offs[k*ADDR_W +: ADDR_W];
        end
    end

endmodule

// File: rtl/pair_stride_seq.sv
module pair_stride_seq
    import pair_stride_seq_pkg::*;
#(
    parameter int NUM_DIMS = 6,
    parameter int LIMIT_W  = 16,
    parameter int ADDR_W   = 32,
    parameter int MAX_PKT  = 4096,
    localparam int LEN_W   = $clog2(MAX_PKT) + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [NUM_DIMS*LIMIT_W-1:0] cfg_limit,
    input  logic [NUM_DIMS*ADDR_W-1:0]  cfg_src_stride,
    input  logic [NUM_DIMS*ADDR_W-1:0]  cfg_dst_stride,
    input  logic [ADDR_W-1:0]           cfg_src_base,
    input  logic [ADDR_W-1:0]           cfg_dst_base,
    input  logic [LEN_W-1:0]            cfg_pkt_len,
    output logic                        busy,
    output logic                        cmd_valid,
    input  logic                        cmd_ready,
    output logic [ADDR_W-1:0]           cmd_src_addr,
    output logic [ADDR_W-1:0]           cmd_dst_addr,
    output logic [LEN_W-1:0]            cmd_len,
    output logic                        done
);

    seq_state_e state_q, state_d;

    logic                       load;
    logic                       advance;
    logic                       last_pkt;
    logic [NUM_DIMS-1:0]        at_last_vec;
    logic [NUM_DIMS-1:0]        carry_vec;
    logic [NUM_DIMS-1:0]        step_vec;
    logic [NUM_DIMS*ADDR_W-1:0] src_offs;
    logic [NUM_DIMS*ADDR_W-1:0] dst_offs;
    logic [ADDR_W-1:0]          src_base_q;
    logic [ADDR_W-1:0]          dst_base_q;
    logic [LEN_W-1:0]           len_q;

    assign last_pkt = &at_last_vec;

    // Innermost level steps on a handshake; each outer level takes the carry
    // of the level just inside it.
    assign step_vec[NUM_DIMS-1] = advance;

    genvar g;
    generate
        for (g = 0; g < NUM_DIMS; g++) begin : g_level
            if (g < NUM_DIMS - 1) begin : g_chain
                assign step_vec[g] = carry_vec[g+1];
            end
            pss_loop_level #(
                .LIMIT_W(LIMIT_W),
                .ADDR_W (ADDR_W)
            ) u_level (
                .clk          (clk),
                .rst_n        (rst_n),
                .load         (load),
                .step         (step_vec[g]),
                .lim_in       (cfg_limit[g*LIMIT_W +: LIMIT_W]),
                .src_stride_in(cfg_src_stride[g*ADDR_W +: ADDR_W]),
                .dst_stride_in(cfg_dst_stride[g*ADDR_W +: ADDR_W]),
                .at_last      (at_last_vec[g]),
                .carry        (carry_vec[g]),
                .src_off      (src_offs[g*ADDR_W +: ADDR_W]),
                .dst_off      (dst_offs[g*ADDR_W +: ADDR_W])
            );
        end
    endgenerate

    pss_offset_sum #(.NUM_DIMS(NUM_DIMS), .ADDR_W(ADDR_W)) u_src_sum (
        .base(src_base_q),
        .offs(src_offs),
        .addr(cmd_src_addr)
    );

    pss_offset_sum #(.NUM_DIMS(NUM_DIMS), .ADDR_W(ADDR_W)) u_dst_sum (
        .base(dst_base_q),
        .offs(dst_offs),
        .addr(cmd_dst_addr)
    );

    assign cmd_len = len_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Descriptor scalar fields, captured at launch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_base_q <= '0;
            dst_base_q <= '0;
            len_q      <= '0;
        end else if (load) begin
            src_base_q <= cfg_src_base;
            dst_base_q <= cfg_dst_base;
            len_q      <= cfg_pkt_len;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_EMIT;
            ST_EMIT: if (cmd_ready && last_pkt) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        busy      = 1'b0;
        cmd_valid = 1'b0;
        done      = 1'b0;
        load      = 1'b0;
        advance   = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_EMIT: begin
                busy      = 1'b1;
                cmd_valid = 1'b1;
                advance   = cmd_ready && !last_pkt;
            end
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pair_stride_seq_chk.sv
module pair_stride_seq_chk #(
    parameter int ADDR_W  = 32,
    parameter int MAX_PKT = 4096,
    localparam int LEN_W  = $clog2(MAX_PKT) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [ADDR_W-1:0] cmd_src_addr,
    input logic [ADDR_W-1:0] cmd_dst_addr,
    input logic [LEN_W-1:0]  cmd_len,
    input logic              done
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cmd_valid && !done)); // R1

    AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> cmd_valid); // R2

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_src_addr) && $stable(cmd_dst_addr))); // R6

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && start) |=> (busy && $stable(cmd_len))); // R8

    AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && $past(cmd_valid)) |-> $stable(cmd_len)); // R9

endmodule

bind pair_stride_seq pair_stride_seq_chk #(
    .ADDR_W (ADDR_W),
    .MAX_PKT(MAX_PKT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_src_addr(cmd_src_addr),
    .cmd_dst_addr(cmd_dst_addr),
    .cmd_len     (cmd_len),
    .done        (done)
);

// File: tb/pair_stride_seq_test.sv
`timescale 1ns/1ps
module pair_stride_seq_test;
    localparam int ND = 6;
    localparam int LW = 16;
    localparam int AW = 32;
    localparam int PW = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cmd_ready = 1'b0;
    logic [ND*LW-1:0] cfg_limit = '0;
    logic [ND*AW-1:0] cfg_src_stride = '0;
    logic [ND*AW-1:0] cfg_dst_stride = '0;
    logic [AW-1:0] cfg_src_base = '0;
    logic [AW-1:0] cfg_dst_base = '0;
    logic [PW-1:0] cfg_pkt_len = '0;
    logic busy, cmd_valid, done;
    logic [AW-1:0] cmd_src_addr, cmd_dst_addr;
    logic [PW-1:0] cmd_len;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    int lim [ND];
    logic [AW-1:0] ss [ND];
    logic [AW-1:0] ds [ND];
    logic [AW-1:0] sb, db;
    int plen;

    always #2.5 clk = ~clk;

    pair_stride_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_limit(cfg_limit), .cfg_src_stride(cfg_src_stride),
        .cfg_dst_stride(cfg_dst_stride), .cfg_src_base(cfg_src_base),
        .cfg_dst_base(cfg_dst_base), .cfg_pkt_len(cfg_pkt_len),
        .busy(busy), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_src_addr(cmd_src_addr), .cmd_dst_addr(cmd_dst_addr),
        .cmd_len(cmd_len), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] addr_of(input logic [AW-1:0] base,
                                              input logic [AW-1:0] st [ND],
                                              input int ix [ND]);
        logic [AW-1:0] a = base;
        for (int k = 0; k < ND; k++) a = a + st[k] * AW'(ix[k]);
        return a;
    endfunction

    task automatic apply_cfg();
        for (int k = 0; k < ND; k++) begin
            cfg_limit[k*LW +: LW]      = LW'(lim[k]);
            cfg_src_stride[k*AW +: AW] = ss[k];
            cfg_dst_stride[k*AW +: AW] = ds[k];
        end
        cfg_src_base = sb;
        cfg_dst_base = db;
        cfg_pkt_len  = PW'(plen);
    endtask

    // rmode 0: ready always high; 1: random ready. poke: start while busy.
    task automatic run_desc(input int rmode, input bit poke, input bit tcase);
        int ix [ND];
        int total = 1;
        int sent = 0;
        bit r;
        logic [AW-1:0] es, ed;
        for (int k = 0; k < ND; k++) begin
            ix[k] = 0;
            total = total * lim[k];
        end
        @(negedge clk);
        apply_cfg();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cmd_valid && busy, "R2 valid after start", 32'(cmd_valid), 1);
        chk(cmd_src_addr == sb, "R2 src base", cmd_src_addr, sb);
        chk(cmd_dst_addr == db, "R2 dst base", cmd_dst_addr, db);
        while (sent < total) begin
            es = addr_of(sb, ss, ix);
            ed = addr_of(db, ds, ix);
            chk(cmd_valid && !done, "R5 valid before last", 32'(cmd_valid), 1);
            chk(cmd_src_addr == es, "R3 src addr", cmd_src_addr, es);
            chk(cmd_dst_addr == ed, "R3 dst addr", cmd_dst_addr, ed);
            chk(cmd_len == PW'(plen), "R9 length", 32'(cmd_len), plen);
            if (tcase && sent == 1) begin
                chk(cmd_src_addr == 256 && cmd_dst_addr == 18432, "R10 src", cmd_src_addr, 256);
                chk(cmd_dst_addr == 18432, "R10 dst", cmd_dst_addr, 18432);
            end
            if (tcase && sent == 8) begin
                chk(cmd_src_addr == 2048 && cmd_dst_addr == 16384 + 256, "R4 outer carry", cmd_src_addr, 2048);
            end
            if (!cmd_valid) break;
            r = (rmode == 0) ? 1'b1 : (($urandom % 3) != 0);
            cmd_ready = r;
            if (poke && sent == 1) begin
                start = 1'b1;
                cfg_src_base = ~sb;
                cfg_pkt_len = PW'(plen == 1 ? 2 : 1);
            end
            @(negedge clk);
            if (poke && sent == 1) begin
                start = 1'b0;
                apply_cfg();
                chk(busy && cmd_len == PW'(plen), "R8 start ignored", 32'(cmd_len), plen);
            end
            if (r) begin
                sent++;
                for (int k = ND - 1; k >= 0; k--) begin
                    if (ix[k] + 1 < lim[k]) begin
                        ix[k]++;
                        break;
                    end
                    ix[k] = 0;
                end
            end else begin
                chk(cmd_valid && cmd_src_addr == es && cmd_dst_addr == ed, "R6 stall hold", cmd_src_addr, es);
            end
        end
        cmd_ready = 1'b0;
        chk(done && !cmd_valid, "R7 done pulse", 32'(done), 1);
        chk(sent == total, "R5 packet count", sent, total);
        @(negedge clk);
        chk(!done && !busy, "R7 back to idle", 32'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 20240611;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        chk(!busy && !cmd_valid && !done, "R1 reset state", {busy, cmd_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !cmd_valid && !done, "R1 idle after reset", {busy, cmd_valid, done}, 0);

        // Directed transpose case
        for (int k = 0; k < ND; k++) begin
            lim[k] = 1; ss[k] = 0; ds[k] = 0;
        end
        lim[0] = 8; ss[0] = 2048; ds[0] = 256;
        lim[1] = 8; ss[1] = 256;  ds[1] = 2048;
        lim[2] = 1; ss[2] = 1;    ds[2] = 1;
        sb = 0; db = 16384; plen = 256;
        run_desc(0, 0, 1);

        // Single packet, both length extremes, with stalls
        for (int k = 0; k < ND; k++) begin
            lim[k] = 1; ss[k] = $urandom; ds[k] = $urandom;
        end
        sb = 32'hFFFF_FF00; db = 32'h10; plen = 1;
        run_desc(1, 0, 0);
        plen = 4096;
        run_desc(1, 0, 0);

        // Random descriptors, random backpressure, one start-while-busy poke
        for (int t = 0; t < 8; t++) begin
            for (int k = 0; k < ND; k++) begin
                lim[k] = 1 + int'($urandom % 3);
                ss[k] = $urandom;
                ds[k] = $urandom;
            end
            lim[ND-1] = 2 + int'($urandom % 2);
            sb = $urandom; db = $urandom;
            plen = 1 + int'($urandom % 4096);
            run_desc(t % 2, t == 1, 0);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule